// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

The block is a binary counter built from 4-bit cells that all advance on the rising clock edge, so every output bit changes together and never ripples. Each cell can be preset synchronously from a parallel data bus. It counts up or down under a direction input. It advances only when two active-low enables are both asserted. One of those enables also gates the cell's terminal-count output, which is active-low and combinational. That output marks the top of the range when counting up and zero when counting down.

The top module chains a parameterizable number of cells into one wide counter. All cells share the clock, the preset, the direction and the first-level enable. Each cell takes its carry-enable from the terminal-count output of the cell below it, so the chain counts as a single binary counter and needs no extra gating. The last terminal-count output becomes the chain's own carry, which lets chains be cascaded further. The asynchronous reset only clears the count for simulation start-up.

Top module: `updown_count_chain`

## Requirements
- R1: While rst_ni is low, count_o is 0.
- R2: When load_ni is low at a rising edge, count_o equals the data_i sampled at that edge after the edge, whatever en_ni, cen_ni and up_i are (preset has priority over counting).
- R3: With load_ni high, count_o holds its value across an edge unless en_ni and cen_ni are both low at that edge.
- R4: With load_ni high, en_ni and cen_ni low and up_i high (1 = up), count_o increments by one modulo 2^TOTAL_W, so all-ones wraps to 0.
- R5: With load_ni high, en_ni and cen_ni low and up_i low (0 = down), count_o decrements by one modulo 2^TOTAL_W, so 0 wraps to all-ones.
- R6: carry_no is low exactly when cen_ni is low and count_o is all-ones with up_i high, or all-zeros with up_i low. It follows its inputs combinationally within the same clock cycle and has no register.
- R7: With the default two 4-bit cells, a lower cell's carry enables the upper cell, so the chain behaves as one 8-bit counter (for example 8'h0F up gives 8'h10, and 8'h10 down gives 8'h0F).
- R8: up_i and en_ni may change anywhere inside a clock period; only their values at the rising edge decide the next count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, clears count |
| load_ni | input | 1 | Active-low synchronous preset |
| data_i | input | TOTAL_W | Preset value |
| up_i | input | 1 | Direction: 1 = up, 0 = down |
| en_ni | input | 1 | Active-low count enable shared by all cells |
| cen_ni | input | 1 | Active-low count and carry enable of the lowest cell |
| count_o | output | TOTAL_W | Current count |
| carry_no | output | 1 | Active-low chain terminal-count carry |

## Verification
The count is driven up across the 8'h0F/8'h10 cell boundary and down across it, which separates a correct cell-to-cell carry from one that enables the upper cell every cycle or never. Both wrap points are crossed in each direction, and the carry is sampled there with cen_ni low and high, which separates the terminal test for up from the one for down and shows the enable gating. The preset is applied while the enables are asserted, which checks its priority. A long pseudo-random mix of preset, direction and both enables is then compared every clock against a behavioural integer model. In a separate step, inputs change mid-period before the edge, which shows that only the values at the edge count.

// File: rtl/updown_pkg.sv
package updown_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  localparam int unsigned CELL_W_DEF = 4;
endpackage

// File: rtl/updown_term_detect.sv
module updown_term_detect #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] value_i,
  input  logic         up_i,
  output logic         at_term_o
);
  import updown_pkg::*;

  logic all_ones, all_zeros;
  assign all_ones  = &value_i;
  assign all_zeros = ~|value_i;

  always_comb begin
    unique case (dir_e'(up_i))
      DIR_UP:   at_term_o = all_ones;
      default:  at_term_o = all_zeros;
    endcase
  end
endmodule

// File: rtl/updown_cell.sv
module updown_cell #(
  parameter int unsigned W = updown_pkg::CELL_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         up_i,
  input  logic         en_ni,
  input  logic         cen_ni,
  output logic [W-1:0] count_o,
  output logic         carry_no
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         step;
  logic         at_term;

  assign step = ~en_ni & ~cen_ni;

  always_comb begin
    cnt_d = cnt_q;
    if (!load_ni)   cnt_d = data_i;
    else if (step)  cnt_d = up_i ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  updown_term_detect #(.W(W)) u_term (
    .value_i   (cnt_q),
    .up_i      (up_i),
    .at_term_o (at_term)
  );

  // carry-enable gates the terminal flag only, not the clock path
  assign carry_no = ~(~cen_ni & at_term);
  assign count_o  = cnt_q;
endmodule

// File: rtl/updown_count_chain.sv
module updown_count_chain #(
  parameter int unsigned STAGE_W    = updown_pkg::CELL_W_DEF,
  parameter int unsigned NUM_STAGES = 2,
  localparam int unsigned TOTAL_W   = STAGE_W * NUM_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic [TOTAL_W-1:0] data_i,
  input  logic               up_i,
  input  logic               en_ni,
  input  logic               cen_ni,
  output logic [TOTAL_W-1:0] count_o,
  output logic               carry_no
);
  logic [NUM_STAGES:0] cen_link;

  assign cen_link[0] = cen_ni;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    updown_cell #(.W(STAGE_W)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_ni  (load_ni),
      .data_i   (data_i[k*STAGE_W +: STAGE_W]),
      .up_i     (up_i),
      .en_ni    (en_ni),
      .cen_ni   (cen_link[k]),
      .count_o  (count_o[k*STAGE_W +: STAGE_W]),
      .carry_no (cen_link[k+1])
    );
  end

  assign carry_no = cen_link[NUM_STAGES];
endmodule

// File: rtl/updown_count_chain_chk.sv
module updown_count_chain_chk #(
  parameter int unsigned TOTAL_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_ni,
  input logic [TOTAL_W-1:0] data_i,
  input logic               up_i,
  input logic               en_ni,
  input logic               cen_ni,
  input logic [TOTAL_W-1:0] count_o,
  input logic               carry_no
);
  logic at_end;
  assign at_end = up_i ? (count_o == {TOTAL_W{1'b1}}) : (count_o == '0);

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0);

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (en_ni || cen_ni)) |=> $stable(count_o));

  a_r4_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && !cen_ni && up_i)
      |=> count_o == TOTAL_W'($past(count_o) + 1'b1));

  a_r5_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && !cen_ni && !up_i)
      |=> count_o == TOTAL_W'($past(count_o) - 1'b1));

  a_r6_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_no == !(!cen_ni && at_end));
endmodule

bind updown_count_chain updown_count_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .load_ni  (load_ni),
  .data_i   (data_i),
  .up_i     (up_i),
  .en_ni    (en_ni),
  .cen_ni   (cen_ni),
  .count_o  (count_o),
  .carry_no (carry_no)
);

// File: tb/updown_count_chain_tb.sv
`timescale 1ns/1ps
module updown_count_chain_tb;
  localparam int W   = 8;
  localparam int MOD = 256;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         up_i = 1'b1;
  logic         en_ni = 1'b1;
  logic         cen_ni = 1'b1;
  logic [W-1:0] count_o;
  logic         carry_no;

  int n_chk = 0;
  int n_bad = 0;
  int ref_cnt = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  updown_count_chain u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .data_i(data_i),
    .up_i(up_i), .en_ni(en_ni), .cen_ni(cen_ni),
    .count_o(count_o), .carry_no(carry_no)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_carry();
    bit term;
    term = up_i ? (ref_cnt == MOD - 1) : (ref_cnt == 0);
    return (!cen_ni && term) ? 0 : 1;
  endfunction

  // behavioural model updated on every edge out of reset
  always @(posedge clk_i) begin
    if (!rst_ni)                  ref_cnt = 0;
    else if (!load_ni)            ref_cnt = int'(data_i);
    else if (!en_ni && !cen_ni)   ref_cnt = up_i ? (ref_cnt + 1) % MOD : (ref_cnt + MOD - 1) % MOD;
  end

  // one clock: drive at negedge, check carry mid-low-phase, check count after edge
  task automatic cyc(input string tag, input bit ld, input int d, input bit up,
                     input bit en, input bit cen);
    @(negedge clk_i);
    load_ni = ld; data_i = W'(d); up_i = up; en_ni = en; cen_ni = cen;
    #1 chk({tag, " R6 carry"}, int'(carry_no), exp_carry());
    @(posedge clk_i);
    #1 chk({tag, " count"}, int'(count_o), ref_cnt);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    #12;
    chk("R1 reset count", int'(count_o), 0);
    chk("R6 reset carry cen high", int'(carry_no), 1);
    @(negedge clk_i); rst_ni = 1'b1;

    cyc("R2 preset enables off", 0, 8'h0D, 1, 1, 1);
    chk("R2 value", int'(count_o), 8'h0D);
    cyc("R4 up", 1, 0, 1, 0, 0);
    cyc("R4 up", 1, 0, 1, 0, 0);
    chk("R7 low cell at 0F", int'(count_o), 8'h0F);
    cyc("R7 up across cells", 1, 0, 1, 0, 0);
    chk("R7 carry into upper", int'(count_o), 8'h10);
    cyc("R7 down across cells", 1, 0, 0, 0, 0);
    chk("R7 borrow from upper", int'(count_o), 8'h0F);

    cyc("R2 preset ff", 0, 8'hFF, 1, 0, 0);
    #1 chk("R6 up at max carry low", int'(carry_no), 0);
    cyc("R4 wrap up", 1, 0, 1, 0, 0);
    chk("R4 wrap to 0", int'(count_o), 0);
    cyc("R6 cen high masks", 1, 0, 0, 1, 1);
    #1 chk("R6 cen high at 0 down", int'(carry_no), 1);
    cyc("R5 wrap down", 1, 0, 0, 0, 0);
    chk("R5 wrap to ff", int'(count_o), 8'hFF);
    cyc("R5 down", 1, 0, 0, 0, 0);
    chk("R5 down to fe", int'(count_o), 8'hFE);

    cyc("R3 hold en high", 1, 0, 1, 1, 0);
    chk("R3 hold en", int'(count_o), 8'hFE);
    cyc("R3 hold cen high", 1, 0, 1, 0, 1);
    chk("R3 hold cen", int'(count_o), 8'hFE);
    cyc("R2 load beats count", 0, 8'h5A, 1, 0, 0);
    chk("R2 priority", int'(count_o), 8'h5A);

    // R8: inputs moved inside the period; edge values decide
    @(negedge clk_i);
    load_ni = 1; up_i = 0; en_ni = 1; cen_ni = 0;
    #1 up_i = 1; en_ni = 0;
    @(posedge clk_i);
    #1 chk("R8 late change counts up", int'(count_o), 8'h5B);
    @(negedge clk_i);
    en_ni = 0; up_i = 1;
    #1 en_ni = 1; up_i = 0;
    @(posedge clk_i);
    #1 chk("R8 late disable holds", int'(count_o), 8'h5B);

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc("R7 random", lfsr[3:0] != 4'd0, int'(lfsr[15:8]), lfsr[4],
          lfsr[6] & lfsr[5], lfsr[7] & lfsr[9]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule